// File: doc/BRIEF.md
# Precision Time-Protocol System Clock

This block keeps a free-running system time made of a 32-bit seconds count and a 31-bit sub-seconds count. The time can advance in two ways. In coarse mode it moves forward by a programmable 8-bit step on every clock. In fine mode a 32-bit frequency-trim word is added into a 32-bit accumulator on every clock, and the step is applied only on the cycles where that addition carries out. Software trims the local rate against a remote master by changing the trim word. The sub-seconds count wraps either at 2^31 (binary, roughly 0.47 ns per unit) or after 999,999,999 (one unit per nanosecond). In both cases the wrap carries into seconds.

Software can also apply a one-shot signed offset, given as seconds and sub-seconds, to jump the time forward or back. That same command also sets an absolute time after reset. A comparator checks the running time against a programmed target and sets a sticky flag that drives an interrupt output.

All configuration goes through a simple register port with separate write and read strobes. The current time is also driven directly on output ports.

Top module: `ptp_time_counter`

## Requirements
- R1: In fine mode (control bit 0 = 1) the trim word at address 0x2 is added into a 32-bit accumulator on every clock, and time advances by the step only on cycles whose addition carries out. After n clocks from an accumulator of zero, time has advanced by floor(n*trim/2^32) steps, so a zero trim word holds the time still.
- R2: In coarse mode (control bit 0 = 0) the sub-seconds advance by the step at address 0x1 (bits 7:0) on every clock, and the trim word has no effect.
- R3: In binary mode (control bit 1 = 0) a sub-seconds sum that reaches 2^31 wraps to the excess and adds one to seconds.
- R4: In decimal mode (control bit 1 = 1) a sub-seconds sum that reaches 1,000,000,000 wraps to the excess and adds one to seconds, so sub-seconds never exceed 999,999,999.
- R5: The offset is seconds at address 0x3 plus a word at address 0x4 whose bits 30:0 are sub-seconds and whose bit 31 selects direction (1 subtract, 0 add). Adding carries one second on sub-seconds overflow. Subtracting borrows one second and wraps sub-seconds to the rollover limit minus the shortfall.
- R6: Writing control with bit 3 = 1 applies the offset at that clock edge instead of that cycle's step. Bit 3 is not stored and reads back as 0.
- R7: With control bit 2 = 1, the flag sets one clock after the unsigned compare {seconds, sub-seconds} >= {target seconds (0x5), target sub-seconds (0x6, bits 30:0)} becomes true. With bit 2 = 0 it never sets.
- R8: The flag is sticky and drives the interrupt output. Writing 1 to bit 0 of address 0x7 clears it, and writing 0 there leaves it set.
- R9: After reset the time, the flag, the accumulator and every register read back as zero.
- R10: When the read strobe is high, read data is loaded one clock later with the register at the given address; it holds its value when the strobe is low. Seconds read at address 0x8, sub-seconds at 0x9, and the flag at bit 0 of 0x7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after rdEn |
| timeSec | output | 32 | System time, seconds |
| timeSub | output | 31 | System time, sub-seconds |
| targetIrq | output | 1 | Sticky target-time-reached interrupt |

## Verification
A wrong step, wrap limit or carry shows on the time ports on the very next clock. The bench sweeps cycle by cycle across the wrap point, so an off-by-one rollover or a missed seconds carry is caught in the cycle it happens. A mistake in the trim accumulator appears as a tick count that drifts away from floor(n*trim/2^32) within a few dozen cycles. A wrong compare or wrong flag handling changes the interrupt pin one cycle early or late, and the bench checks every cycle around the crossing.

// File: rtl/ptp_time_pkg.sv
package ptp_time_pkg;

  localparam int SecW  = 32;
  localparam int SubW  = 31;
  localparam int AccW  = 32;
  localparam int IncW  = 8;
  localparam int AddrW = 4;
  localparam int DataW = 32;
  localparam int WideW = SubW + 1;

  localparam logic [WideW-1:0] NsPerSec = WideW'(1_000_000_000);
  localparam logic [WideW-1:0] BinWrap  = WideW'(1) << SubW;

  localparam int CtrlFineBit = 0;
  localparam int CtrlDecBit  = 1;
  localparam int CtrlIrqBit  = 2;
  localparam int CtrlGoBit   = 3;
  localparam int OfsSignBit  = DataW - 1;

  typedef enum logic [AddrW-1:0] {
    REG_CTRL     = 4'h0,
    REG_STEP     = 4'h1,
    REG_TRIM     = 4'h2,
    REG_OFS_SEC  = 4'h3,
    REG_OFS_SUB  = 4'h4,
    REG_TGT_SEC  = 4'h5,
    REG_TGT_SUB  = 4'h6,
    REG_STATUS   = 4'h7,
    REG_TIME_SEC = 4'h8,
    REG_TIME_SUB = 4'h9
  } regAddr_e;

  typedef struct packed {
    logic            fineMode;
    logic            decimalMode;
    logic            irqEnable;
    logic [IncW-1:0] step;
    logic [AccW-1:0] trim;
    logic [SecW-1:0] ofsSec;
    logic [SubW-1:0] ofsSub;
    logic            ofsSubtract;
    logic [SecW-1:0] tgtSec;
    logic [SubW-1:0] tgtSub;
  } timeCfg_t;

  typedef struct packed {
    logic applyOffset;
    logic clearFlag;
  } timeStrobe_t;

endpackage

// File: rtl/ptp_addend_acc.sv
module ptp_addend_acc
  import ptp_time_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [AccW-1:0] trim,
  output logic            carry
);

  logic [AccW-1:0] accQ;
  logic [AccW:0]   sumWide;

  assign sumWide = {1'b0, accQ} + {1'b0, trim};
  assign carry   = enable & sumWide[AccW];

  // The remainder is kept across offset updates; it only moves in fine mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
    end else if (enable) begin
      accQ <= sumWide[AccW-1:0];
    end
  end

  // R1: without fine mode the accumulator must not move.
  p_acc_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!enable) |=> $stable(accQ));

endmodule

// File: rtl/ptp_target_cmp.sv
module ptp_target_cmp
  import ptp_time_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [SecW-1:0] timeSec,
  input  logic [SubW-1:0] timeSub,
  input  logic [SecW-1:0] tgtSec,
  input  logic [SubW-1:0] tgtSub,
  input  logic            irqEnable,
  input  logic            clearFlag,
  output logic            flag
);

  localparam int CmpW = SecW + SubW;

  logic [CmpW-1:0] nowKey;
  logic [CmpW-1:0] tgtKey;
  logic            reached;
  logic            flagQ;

  assign nowKey  = {timeSec, timeSub};
  assign tgtKey  = {tgtSec, tgtSub};
  assign reached = nowKey >= tgtKey;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else begin
      flagQ <= (flagQ & ~clearFlag) | (irqEnable & reached);
    end
  end

  assign flag = flagQ;

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagQ && !clearFlag) |=> flagQ);

  p_flag_gated_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!flagQ && !irqEnable) |=> !flagQ);

endmodule

// File: rtl/ptp_time_datapath.sv
module ptp_time_datapath
  import ptp_time_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  timeCfg_t        cfg,
  input  timeStrobe_t     strobe,
  output logic [SecW-1:0] timeSec,
  output logic [SubW-1:0] timeSub,
  output logic            targetFlag
);

  localparam logic [SecW-1:0] SecOne = SecW'(1);

  logic [SecW-1:0]  secQ, secD;
  logic [SubW-1:0]  subQ, subD;
  logic             accCarry;
  logic             tick;
  logic [WideW-1:0] wrapLimit;
  logic [WideW-1:0] subWide;
  logic [WideW-1:0] stepSum;
  logic [WideW-1:0] ofsSum;
  logic [WideW-1:0] ofsDiff;
  logic [WideW-1:0] borrowFix;
  logic             stepWrap;
  logic             ofsWrap;
  logic             ofsBorrow;

  ptp_addend_acc u_acc (
    .clk    (clk),
    .rstN   (rstN),
    .enable (cfg.fineMode),
    .trim   (cfg.trim),
    .carry  (accCarry)
  );

  assign tick      = cfg.fineMode ? accCarry : 1'b1;
  assign wrapLimit = cfg.decimalMode ? NsPerSec : BinWrap;
  assign subWide   = {1'b0, subQ};

  assign stepSum   = subWide + WideW'(cfg.step);
  assign stepWrap  = stepSum >= wrapLimit;

  assign ofsSum    = subWide + {1'b0, cfg.ofsSub};
  assign ofsWrap   = ofsSum >= wrapLimit;
  assign ofsDiff   = subWide - {1'b0, cfg.ofsSub};
  assign ofsBorrow = ofsDiff[SubW];
  assign borrowFix = ofsDiff + wrapLimit;

  always_comb begin
    secD = secQ;
    subD = subQ;
    if (strobe.applyOffset) begin
      if (cfg.ofsSubtract) begin
        if (ofsBorrow) begin
          subD = borrowFix[SubW-1:0];
          secD = secQ - cfg.ofsSec - SecOne;
        end else begin
          subD = ofsDiff[SubW-1:0];
          secD = secQ - cfg.ofsSec;
        end
      end else begin
        if (ofsWrap) begin
          subD = SubW'(ofsSum - wrapLimit);
          secD = secQ + cfg.ofsSec + SecOne;
        end else begin
          subD = ofsSum[SubW-1:0];
          secD = secQ + cfg.ofsSec;
        end
      end
    end else if (tick) begin
      if (stepWrap) begin
        subD = SubW'(stepSum - wrapLimit);
        secD = secQ + SecOne;
      end else begin
        subD = stepSum[SubW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ <= '0;
      subQ <= '0;
    end else begin
      secQ <= secD;
      subQ <= subD;
    end
  end

  ptp_target_cmp u_cmp (
    .clk       (clk),
    .rstN      (rstN),
    .timeSec   (secQ),
    .timeSub   (subQ),
    .tgtSec    (cfg.tgtSec),
    .tgtSub    (cfg.tgtSub),
    .irqEnable (cfg.irqEnable),
    .clearFlag (strobe.clearFlag),
    .flag      (targetFlag)
  );

  assign timeSec = secQ;
  assign timeSub = subQ;

  p_zero_trim_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.fineMode && cfg.trim == '0 && !strobe.applyOffset)
      |=> ($stable(subQ) && $stable(secQ)));

  p_coarse_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.fineMode && !strobe.applyOffset && !stepWrap)
      |=> (subQ - $past(subQ) == SubW'($past(cfg.step))));

  p_sec_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.applyOffset) |=> (secQ == $past(secQ) || secQ == $past(secQ) + SecOne));

  p_dec_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.decimalMode && subWide < NsPerSec && {1'b0, cfg.ofsSub} < NsPerSec)
      |=> (!cfg.decimalMode || subWide < NsPerSec));

endmodule

// File: rtl/ptp_time_regs.sv
module ptp_time_regs
  import ptp_time_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wrData,
  input  logic [SecW-1:0]  timeSec,
  input  logic [SubW-1:0]  timeSub,
  input  logic             targetFlag,
  output timeCfg_t         cfg,
  output timeStrobe_t      strobe,
  output logic [DataW-1:0] rdData
);

  regAddr_e         addrE;
  logic             fineQ, decQ, irqEnQ;
  logic [IncW-1:0]  stepQ;
  logic [AccW-1:0]  trimQ;
  logic [SecW-1:0]  ofsSecQ;
  logic [DataW-1:0] ofsWordQ;
  logic [SecW-1:0]  tgtSecQ;
  logic [SubW-1:0]  tgtSubQ;
  logic [DataW-1:0] rdNext;
  logic [DataW-1:0] rdQ;

  assign addrE = regAddr_e'(addr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fineQ    <= 1'b0;
      decQ     <= 1'b0;
      irqEnQ   <= 1'b0;
      stepQ    <= '0;
      trimQ    <= '0;
      ofsSecQ  <= '0;
      ofsWordQ <= '0;
      tgtSecQ  <= '0;
      tgtSubQ  <= '0;
    end else if (wrEn) begin
      case (addrE)
        REG_CTRL: begin
          fineQ  <= wrData[CtrlFineBit];
          decQ   <= wrData[CtrlDecBit];
          irqEnQ <= wrData[CtrlIrqBit];
        end
        REG_STEP:    stepQ    <= wrData[IncW-1:0];
        REG_TRIM:    trimQ    <= wrData[AccW-1:0];
        REG_OFS_SEC: ofsSecQ  <= wrData[SecW-1:0];
        REG_OFS_SUB: ofsWordQ <= wrData;
        REG_TGT_SEC: tgtSecQ  <= wrData[SecW-1:0];
        REG_TGT_SUB: tgtSubQ  <= wrData[SubW-1:0];
        default: ;
      endcase
    end
  end

  // Command strobes act at the same edge as the write and are never stored.
  always_comb begin
    strobe.applyOffset = wrEn && (addrE == REG_CTRL) && wrData[CtrlGoBit];
    strobe.clearFlag   = wrEn && (addrE == REG_STATUS) && wrData[0];
  end

  always_comb begin
    cfg.fineMode    = fineQ;
    cfg.decimalMode = decQ;
    cfg.irqEnable   = irqEnQ;
    cfg.step        = stepQ;
    cfg.trim        = trimQ;
    cfg.ofsSec      = ofsSecQ;
    cfg.ofsSub      = ofsWordQ[SubW-1:0];
    cfg.ofsSubtract = ofsWordQ[OfsSignBit];
    cfg.tgtSec      = tgtSecQ;
    cfg.tgtSub      = tgtSubQ;
  end

  always_comb begin
    rdNext = '0;
    case (addrE)
      REG_CTRL: begin
        rdNext[CtrlFineBit] = fineQ;
        rdNext[CtrlDecBit]  = decQ;
        rdNext[CtrlIrqBit]  = irqEnQ;
      end
      REG_STEP:     rdNext = DataW'(stepQ);
      REG_TRIM:     rdNext = DataW'(trimQ);
      REG_OFS_SEC:  rdNext = DataW'(ofsSecQ);
      REG_OFS_SUB:  rdNext = ofsWordQ;
      REG_TGT_SEC:  rdNext = DataW'(tgtSecQ);
      REG_TGT_SUB:  rdNext = DataW'(tgtSubQ);
      REG_STATUS:   rdNext[0] = targetFlag;
      REG_TIME_SEC: rdNext = DataW'(timeSec);
      REG_TIME_SUB: rdNext = DataW'(timeSub);
      default:      rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (rdEn) begin
      rdQ <= rdNext;
    end
  end

  assign rdData = rdQ;

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn) |=> $stable(rdQ));

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
  import ptp_time_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AddrW-1:0] addr,
  input  logic [DataW-1:0] wrData,
  output logic [DataW-1:0] rdData,
  output logic [SecW-1:0]  timeSec,
  output logic [SubW-1:0]  timeSub,
  output logic             targetIrq
);

  timeCfg_t    cfg;
  timeStrobe_t strobe;
  logic        flag;

  ptp_time_regs u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .addr       (addr),
    .wrData     (wrData),
    .timeSec    (timeSec),
    .timeSub    (timeSub),
    .targetFlag (flag),
    .cfg        (cfg),
    .strobe     (strobe),
    .rdData     (rdData)
  );

  ptp_time_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfg        (cfg),
    .strobe     (strobe),
    .timeSec    (timeSec),
    .timeSub    (timeSub),
    .targetFlag (flag)
  );

  assign targetIrq = flag;

endmodule

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] timeSec;
  logic [30:0] timeSub;
  logic        targetIrq;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  localparam longint unsigned LBin = 64'h8000_0000;
  localparam longint unsigned LDec = 64'd1_000_000_000;

  always #10 clk = ~clk;

  ptp_time_counter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .timeSec(timeSec), .timeSub(timeSub),
    .targetIrq(targetIrq)
  );

  task automatic checkEq(input string req, input longint unsigned act, input longint unsigned exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkTime(input string req, input longint unsigned total, input longint unsigned lim);
    checkEq(req, {32'd0, timeSec}, (total / lim) & 64'hFFFF_FFFF);
    checkEq(req, {33'd0, timeSub}, total % lim);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic setTime(input logic [31:0] mode, input logic [31:0] s, input logic [30:0] sub);
    wr(4'h3, s);
    wr(4'h4, {1'b0, sub});
    wr(4'h0, mode | 32'h8);
  endtask

  initial begin
    logic [31:0] d;
    longint unsigned total, lim, t0;
    logic [31:0] mode;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R9: reset state
    checkEq("R9 sec", timeSec, 0);
    checkEq("R9 sub", timeSub, 0);
    checkEq("R9 irq", targetIrq, 0);
    rd(4'h2, d); checkEq("R9 trim", d, 0);
    rd(4'h5, d); checkEq("R9 tgtsec", d, 0);
    rd(4'h4, d); checkEq("R9 ofssub", d, 0);

    // R2 R3 R4: coarse sweeps across the wrap in both formats, trim ignored
    for (int fmt = 0; fmt < 2; fmt++) begin
      for (int k = 0; k < 3; k++) begin
        automatic int stepV = (k == 0) ? 1 : ((k == 1) ? 200 : 255);
        lim  = (fmt == 0) ? LBin : LDec;
        mode = (fmt == 0) ? 32'h0 : 32'h2;
        doReset();
        total = lim - 10 * stepV;
        setTime(mode, 32'd0, 31'(total));
        wr(4'h2, 32'hFFFF_FFFF);
        wr(4'h1, stepV);
        for (int n = 1; n <= 40; n++) begin
          @(negedge clk);
          checkTime((fmt == 0) ? "R2 R3 binary step" : "R2 R4 decimal step",
                    total + longint'(n) * stepV, lim);
        end
      end
    end

    // R1: fine mode, ticks = floor(n*trim/2^32)
    for (int k = 0; k < 4; k++) begin
      automatic logic [31:0] trimV = (k == 0) ? 32'h4000_0000 : (k == 1) ? 32'h9000_0000 :
                                     (k == 2) ? 32'h0 : 32'h1234_5678;
      doReset();
      wr(4'h0, 32'h1);
      wr(4'h1, 32'd3);
      wr(4'h2, trimV);
      for (int n = 1; n <= 64; n++) begin
        @(negedge clk);
        checkEq("R1 fine sub", timeSub, 3 * ((longint'(n) * trimV) >> 32));
        checkEq("R1 fine sec", timeSec, 0);
      end
    end

    // R5: signed offsets with carry and borrow in both formats
    for (int fmt = 0; fmt < 2; fmt++) begin
      lim  = (fmt == 0) ? LBin : LDec;
      mode = (fmt == 0) ? 32'h0 : 32'h2;
      doReset();
      setTime(mode, 32'd10, 31'd100);
      total = 10 * lim + 100;
      checkTime("R5 set", total, lim);
      wr(4'h3, 32'd3); wr(4'h4, {1'b1, 31'd500}); wr(4'h0, mode | 32'h8);
      total = total - (3 * lim + 500);
      checkTime("R5 sub borrow", total, lim);
      wr(4'h3, 32'd2); wr(4'h4, {1'b1, 31'd40}); wr(4'h0, mode | 32'h8);
      total = total - (2 * lim + 40);
      checkTime("R5 sub plain", total, lim);
      wr(4'h3, 32'd1); wr(4'h4, {1'b0, 31'(lim - 50)}); wr(4'h0, mode | 32'h8);
      total = total + (lim + lim - 50);
      checkTime("R5 add carry", total, lim);
      wr(4'h3, 32'd4); wr(4'h4, {1'b0, 31'd7}); wr(4'h0, mode | 32'h8);
      total = total + (4 * lim + 7);
      checkTime("R5 add plain", total, lim);
    end

    // R6: offset replaces the step in its cycle; command bit reads 0
    doReset();
    wr(4'h1, 32'd7);
    repeat (5) @(negedge clk);
    wr(4'h3, 32'd2);
    wr(4'h4, {1'b0, 31'd1000});
    t0 = {32'd0, timeSec} * LBin + timeSub;
    wr(4'h0, 32'h8);
    checkTime("R6 priority", t0 + 2 * LBin + 1000, LBin);
    @(negedge clk);
    checkTime("R6 resume", t0 + 2 * LBin + 1007, LBin);
    rd(4'h0, d);
    checkEq("R6 go reads 0", d, 0);

    // R7: target crossing, binary
    doReset();
    wr(4'h6, 32'd100);
    wr(4'h0, 32'h4);
    wr(4'h1, 32'd9);
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      checkEq("R7 crossing", targetIrq, (9 * (n - 1) >= 100) ? 1 : 0);
    end
    // R8: sticky and write-one-to-clear
    wr(4'h5, 32'hFFFF_FFFF);
    checkEq("R8 sticky", targetIrq, 1);
    wr(4'h7, 32'h0);
    checkEq("R8 write 0 keeps", targetIrq, 1);
    rd(4'h7, d);
    checkEq("R10 status read", d, 1);
    wr(4'h7, 32'h1);
    checkEq("R8 clear", targetIrq, 0);
    repeat (5) @(negedge clk);
    checkEq("R8 stays clear", targetIrq, 0);
    doReset();
    checkEq("R9 irq after reset", targetIrq, 0);

    // R7: seconds take part in the compare (decimal)
    setTime(32'h2, 32'd0, 31'd999_999_990);
    wr(4'h5, 32'd1);
    wr(4'h6, 32'd5);
    wr(4'h0, 32'h6);
    wr(4'h1, 32'd3);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      checkEq("R7 seconds compare", targetIrq, (3 * (n - 1) >= 15) ? 1 : 0);
    end

    // R7: disabled never sets
    doReset();
    wr(4'h6, 32'd50);
    wr(4'h1, 32'd9);
    for (int n = 1; n <= 20; n++) begin
      @(negedge clk);
      checkEq("R7 disabled", targetIrq, 0);
    end
    rd(4'h7, d);
    checkEq("R7 disabled status", d, 0);

    // R10: readback and time registers with time frozen
    doReset();
    setTime(32'h0, 32'd77, 31'd12345);
    wr(4'h2, 32'hCAFE_0001);
    rd(4'h8, d); checkEq("R10 time sec", d, 77);
    rd(4'h9, d); checkEq("R10 time sub", d, 12345);
    rd(4'h2, d); checkEq("R10 trim", d, 32'hCAFE_0001);
    @(negedge clk);
    checkEq("R10 hold", rdData, 32'hCAFE_0001);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  end

endmodule